// File: doc/BRIEF.md
# Bidirectional Byte-Wide Printer Port Engine

This block moves single bytes across a Centronics-style printer port and runs on the system bus clock. In forward mode it takes a byte from an upstream source, puts it on the port data lines, waits a programmable setup time, and raises a data strobe for a programmable width. It then waits for the peripheral's acknowledge pulse to end before it accepts the next byte. In reverse mode the peripheral strobes a byte in. The engine answers with busy, hands the byte downstream, pulses acknowledge, and releases busy once the peripheral's strobe is low again.

One direction bit sets the four external transceiver direction outputs together. It also selects which of the two transfer engines is active. The incoming strobe, acknowledge and busy lines each pass through a two-flop synchronizer before any edge is detected. All port-side signals are active high at this block's boundary.

Both byte paths use valid/ready handshakes. In forward mode, `tx_ready` is high only when the engine is idle, the port is set to forward, and the synchronized peripheral busy is low. A byte transfers on any clock edge where `tx_valid` and `tx_ready` are both high. In reverse mode, `rx_valid` stays high and `rx_data` stays constant until the edge where `rx_ready` is high. Until that edge, busy stays asserted, and this is how the peripheral is held back.

An interrupt-pending flag marks each finished byte. The three printer control outputs are registered copies of control inputs.

Top module: `lpt_engine`

## Requirements
- R1: After reset, and while `cfg_dir` is 0 (forward), `dir_data_o` and `dir_stb_o` are 1 and `dir_busy_o` and `dir_ack_o` are 0. A change of `cfg_dir` reaches these outputs one clock later.
- R2: While `cfg_dir` is 1 (reverse), `dir_data_o` and `dir_stb_o` are 0 and `dir_busy_o` and `dir_ack_o` are 1.
- R3: In forward mode, `pp_stb_o` stays high for exactly `cfg_width` + 3 clock periods, where `cfg_width` is a 2-bit field (0 to 3).
- R4: In forward mode, `pp_data_o` carries the accepted byte from the clock after acceptance until the transfer completes. `pp_stb_o` rises `cfg_setup` + 1 periods after acceptance, where `cfg_setup` is 2 bits. `pp_data_o` does not change while the strobe is high.
- R5: `tx_ready` is low while `cfg_dir` is 1, while a forward transfer is in progress, and while the synchronized `pp_busy_i` is high. A byte offered during any of these conditions does not start a strobe.
- R6: A forward transfer completes on the falling edge of the synchronized `pp_ack_i`. No completion is flagged and no new byte is accepted before that edge.
- R7: In reverse mode, a rising `pp_stb_i` makes `pp_busy_o` rise 2 to 3 clock periods later. The byte on `pp_data_i` is presented on `rx_data` with `rx_valid` high, and both are held until `rx_ready`.
- R8: After the reverse handshake, `pp_ack_o` is high for exactly 3 periods with `pp_busy_o` high. `pp_busy_o` then stays high until the synchronized `pp_stb_i` is low.
- R9: Each completed byte, in either direction, sets a pending flag. `irq_o` equals pending AND `irq_en`. A pulse on `irq_clr` clears the flag, and a completion in the same cycle takes precedence over the clear.
- R10: `init_o`, `selin_o` and `autofd_o` follow `cfg_init`, `cfg_selin` and `cfg_autofd` one clock later.
- R11: In forward mode, `pp_stb_i` pulses are ignored: `pp_busy_o`, `pp_ack_o` and `rx_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir | input | 1 | Transfer direction: 0 forward, 1 reverse |
| cfg_setup | input | 2 | Data setup before strobe, in extra periods |
| cfg_width | input | 2 | Strobe width beyond the 3-period minimum |
| cfg_init | input | 1 | Requested level of the init output |
| cfg_selin | input | 1 | Requested level of the select-in output |
| cfg_autofd | input | 1 | Requested level of the auto-feed output |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the pending flag |
| tx_valid | input | 1 | Forward byte offered |
| tx_ready | output | 1 | Forward byte can be taken |
| tx_data | input | 8 | Forward byte |
| rx_valid | output | 1 | Reverse byte available |
| rx_ready | input | 1 | Downstream takes the reverse byte |
| rx_data | output | 8 | Reverse byte |
| pp_data_o | output | 8 | Port data driven in forward mode |
| pp_data_i | input | 8 | Port data sampled in reverse mode |
| pp_stb_o | output | 1 | Outgoing data strobe |
| pp_stb_i | input | 1 | Incoming data strobe |
| pp_ack_o | output | 1 | Outgoing acknowledge |
| pp_ack_i | input | 1 | Incoming acknowledge |
| pp_busy_o | output | 1 | Outgoing busy |
| pp_busy_i | input | 1 | Incoming busy |
| dir_data_o | output | 1 | Data transceiver direction |
| dir_stb_o | output | 1 | Strobe transceiver direction |
| dir_busy_o | output | 1 | Busy transceiver direction |
| dir_ack_o | output | 1 | Acknowledge transceiver direction |
| init_o | output | 1 | Printer init line |
| selin_o | output | 1 | Printer select-in line |
| autofd_o | output | 1 | Printer auto-feed line |
| irq_o | output | 1 | Interrupt request |

## Verification
Several properties are checked on every clock edge:
- the outgoing strobe lasts at least three periods;
- the port data does not move under the strobe;
- a stalled reverse byte keeps both `rx_valid` and its value;
- the outgoing acknowledge lasts at least three periods;
- the pending flag rises only after a completion.

Some behaviours can only be shown by the bench scenarios:
- the exact setup and width counts for each field value;
- the busy latency after an incoming strobe;
- that an offered byte is blocked by peripheral busy or by reverse mode;
- that incoming strobes are ignored in forward mode;
- the direction-output groups;
- the interrupt enable and clear sequence.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [1:0] {F_IDLE, F_SETUP, F_STROBE, F_WAIT_ACK} fwd_st_t;
  typedef enum logic [1:0] {R_IDLE, R_HOLD, R_ACK, R_DRAIN} rev_st_t;
  localparam int unsigned MIN_PULSE = 3;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stab;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta <= 1'b0;
        stab <= 1'b0;
      end else begin
        meta <= d[i];
        stab <= meta;
      end
    end
    assign q[i] = stab;
  end
endmodule

// File: rtl/lpt_fwd.sv
module lpt_fwd
  import lpt_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned SETW = 2,
  parameter int unsigned WIDW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tx_valid,
  input  logic [DW-1:0]   tx_data,
  output logic            tx_ready,
  input  logic [SETW-1:0] setup,
  input  logic [WIDW-1:0] width,
  input  logic            busy_s,
  input  logic            ack_s,
  output logic [DW-1:0]   data_o,
  output logic            stb_o,
  output logic            done
);
  localparam int unsigned CW = ((WIDW > SETW) ? WIDW : SETW) + 2;

  fwd_st_t       st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] data_q;
  logic          ack_d;
  logic          ack_fall;

  assign ack_fall = ack_d & ~ack_s;
  assign tx_ready = en && (st == F_IDLE) && !busy_s;
  assign stb_o    = (st == F_STROBE);
  assign data_o   = data_q;
  assign done     = (st == F_WAIT_ACK) && ack_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      cnt    <= '0;
      data_q <= '0;
      ack_d  <= 1'b0;
    end else begin
      ack_d <= ack_s;
      case (st)
        F_IDLE: if (tx_valid && tx_ready) begin
          data_q <= tx_data;
          cnt    <= CW'(setup);
          st     <= F_SETUP;
        end
        F_SETUP: if (cnt == '0) begin
          cnt <= CW'(width) + CW'(MIN_PULSE - 1);
          st  <= F_STROBE;
        end else begin
          cnt <= cnt - 1'b1;
        end
        F_STROBE: if (cnt == '0) st <= F_WAIT_ACK;
                  else cnt <= cnt - 1'b1;
        F_WAIT_ACK: if (ack_fall) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  // R3: strobe never shorter than three periods
  assert_strobe_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_o) |-> ($past(stb_o, 2) && $past(stb_o, 3)));

  // R4: port data frozen while strobe is high
  assert_data_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o && $past(stb_o)) |-> $stable(data_o));
endmodule

// File: rtl/lpt_rev.sv
module lpt_rev
  import lpt_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          stb_s,
  input  logic [DW-1:0] data_in,
  output logic          rx_valid,
  input  logic          rx_ready,
  output logic [DW-1:0] rx_data,
  output logic          busy_o,
  output logic          ack_o,
  output logic          done
);
  localparam int unsigned AW = $clog2(MIN_PULSE + 1);

  rev_st_t       st;
  logic [AW-1:0] cnt;
  logic [DW-1:0] data_q;
  logic          stb_d;

  assign rx_valid = (st == R_HOLD);
  assign rx_data  = data_q;
  assign busy_o   = (st != R_IDLE);
  assign ack_o    = (st == R_ACK);
  assign done     = (st == R_ACK) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= R_IDLE;
      cnt    <= '0;
      data_q <= '0;
      stb_d  <= 1'b0;
    end else begin
      stb_d <= stb_s;
      case (st)
        R_IDLE: if (en && stb_s && !stb_d) begin
          data_q <= data_in;
          st     <= R_HOLD;
        end
        R_HOLD: if (rx_ready) begin
          cnt <= AW'(MIN_PULSE - 1);
          st  <= R_ACK;
        end
        R_ACK: if (cnt == '0) st <= R_DRAIN;
               else cnt <= cnt - 1'b1;
        R_DRAIN: if (!stb_s) st <= R_IDLE;
        default: st <= R_IDLE;
      endcase
    end
  end

  // R7: a stalled reverse byte keeps valid and value
  assert_rx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R8: acknowledge pulse at least three periods
  assert_ack_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_o) |-> ($past(ack_o, 2) && $past(ack_o, 3)));
endmodule

// File: rtl/lpt_engine.sv
module lpt_engine #(
  parameter int unsigned DW   = 8,
  parameter int unsigned SETW = 2,
  parameter int unsigned WIDW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_dir,
  input  logic [SETW-1:0] cfg_setup,
  input  logic [WIDW-1:0] cfg_width,
  input  logic            cfg_init,
  input  logic            cfg_selin,
  input  logic            cfg_autofd,
  input  logic            irq_en,
  input  logic            irq_clr,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [DW-1:0]   tx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [DW-1:0]   rx_data,
  output logic [DW-1:0]   pp_data_o,
  input  logic [DW-1:0]   pp_data_i,
  output logic            pp_stb_o,
  input  logic            pp_stb_i,
  output logic            pp_ack_o,
  input  logic            pp_ack_i,
  output logic            pp_busy_o,
  input  logic            pp_busy_i,
  output logic            dir_data_o,
  output logic            dir_stb_o,
  output logic            dir_busy_o,
  output logic            dir_ack_o,
  output logic            init_o,
  output logic            selin_o,
  output logic            autofd_o,
  output logic            irq_o
);
  logic [2:0] sync_q;
  logic       dir_q, irq_pend, fwd_done, rev_done;

  lpt_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pp_stb_i, pp_ack_i, pp_busy_i}), .q(sync_q)
  );

  lpt_fwd #(.DW(DW), .SETW(SETW), .WIDW(WIDW)) u_fwd (
    .clk(clk), .rst_n(rst_n), .en(!dir_q),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .setup(cfg_setup), .width(cfg_width),
    .busy_s(sync_q[0]), .ack_s(sync_q[1]),
    .data_o(pp_data_o), .stb_o(pp_stb_o), .done(fwd_done)
  );

  lpt_rev #(.DW(DW)) u_rev (
    .clk(clk), .rst_n(rst_n), .en(dir_q), .stb_s(sync_q[2]),
    .data_in(pp_data_i), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .busy_o(pp_busy_o), .ack_o(pp_ack_o), .done(rev_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= 1'b0;
      init_o   <= 1'b0;
      selin_o  <= 1'b0;
      autofd_o <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      dir_q    <= cfg_dir;
      init_o   <= cfg_init;
      selin_o  <= cfg_selin;
      autofd_o <= cfg_autofd;
      if (fwd_done || rev_done) irq_pend <= 1'b1;
      else if (irq_clr)         irq_pend <= 1'b0;
    end
  end

  assign dir_data_o = !dir_q;
  assign dir_stb_o  = !dir_q;
  assign dir_busy_o = dir_q;
  assign dir_ack_o  = dir_q;
  assign irq_o      = irq_pend && irq_en;

  // R9: pending only rises after a completed byte
  assert_pend_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(fwd_done || rev_done));
endmodule

// File: tb/lpt_engine_tb.sv
`timescale 1ns/1ps
module lpt_engine_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_dir = 0, cfg_init = 0, cfg_selin = 0, cfg_autofd = 0;
  logic [1:0] cfg_setup = 0, cfg_width = 0;
  logic irq_en = 0, irq_clr = 0, tx_valid = 0, rx_ready = 0;
  logic [7:0] tx_data = 0, pp_data_i = 0;
  logic pp_stb_i = 0, pp_ack_i = 0, pp_busy_i = 0;
  logic tx_ready, rx_valid, pp_stb_o, pp_ack_o, pp_busy_o;
  logic [7:0] rx_data, pp_data_o;
  logic dir_data_o, dir_stb_o, dir_busy_o, dir_ack_o;
  logic init_o, selin_o, autofd_o, irq_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lpt_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_setup(cfg_setup),
    .cfg_width(cfg_width), .cfg_init(cfg_init), .cfg_selin(cfg_selin),
    .cfg_autofd(cfg_autofd), .irq_en(irq_en), .irq_clr(irq_clr),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .pp_data_o(pp_data_o), .pp_data_i(pp_data_i), .pp_stb_o(pp_stb_o),
    .pp_stb_i(pp_stb_i), .pp_ack_o(pp_ack_o), .pp_ack_i(pp_ack_i),
    .pp_busy_o(pp_busy_o), .pp_busy_i(pp_busy_i), .dir_data_o(dir_data_o),
    .dir_stb_o(dir_stb_o), .dir_busy_o(dir_busy_o), .dir_ack_o(dir_ack_o),
    .init_o(init_o), .selin_o(selin_o), .autofd_o(autofd_o), .irq_o(irq_o)
  );

  // data[11:4], setup[3:2], width[1:0]
  localparam logic [11:0] VEC [4] = '{
    {8'hA5, 2'd0, 2'd0}, {8'h3C, 2'd3, 2'd3},
    {8'h00, 2'd1, 2'd2}, {8'hFF, 2'd2, 2'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic ack_pulse();
    pp_ack_i = 1;
    repeat (3) @(negedge clk);
    pp_ack_i = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state, R1
    chk(dir_data_o && dir_stb_o && !dir_busy_o && !dir_ack_o, "R1 reset dir", dir_busy_o, 0);
    chk(!pp_stb_o && !pp_busy_o && !irq_o && !rx_valid, "R1 reset outputs", pp_stb_o, 0);
    irq_en = 1;

    foreach (VEC[i]) begin
      int ns, nw;
      logic [7:0] d;
      d = VEC[i][11:4];
      cfg_setup = VEC[i][3:2];
      cfg_width = VEC[i][1:0];
      tx_data = d;
      tx_valid = 1;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid = 0;
      tx_data = ~d;
      ns = 0;
      while (!pp_stb_o && ns < 20) begin ns++; @(negedge clk); end
      chk(ns == int'(VEC[i][3:2]) + 1, "R4 setup", ns, int'(VEC[i][3:2]) + 1);
      chk(pp_data_o == d, "R4 data", pp_data_o, d);
      nw = 0;
      while (pp_stb_o && nw < 20) begin nw++; @(negedge clk); end
      chk(nw == int'(VEC[i][1:0]) + 3, "R3 width", nw, int'(VEC[i][1:0]) + 3);
      repeat (2) @(negedge clk);
      chk(!irq_o && !tx_ready, "R6 wait ack", irq_o, 0);
      chk(pp_data_o == d, "R4 data held", pp_data_o, d);
      ack_pulse();
      chk(irq_o, "R9 fwd irq", irq_o, 1);
      irq_clr = 1; @(negedge clk); irq_clr = 0; @(negedge clk);
      chk(!irq_o, "R9 clear", irq_o, 0);
    end

    // R5: busy blocks a new byte
    pp_busy_i = 1;
    repeat (3) @(negedge clk);
    tx_valid = 1; tx_data = 8'h77;
    repeat (5) begin
      chk(!tx_ready && !pp_stb_o, "R5 busy blocks", tx_ready, 0);
      @(negedge clk);
    end
    pp_busy_i = 0;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 0;
    repeat (8) @(negedge clk);
    chk(pp_data_o == 8'h77, "R5 starts after busy", pp_data_o, 8'h77);
    ack_pulse();

    // R9: enable gating; pending survives while disabled
    irq_clr = 1; @(negedge clk); irq_clr = 0;
    irq_en = 0;

    // R11: incoming strobe ignored in forward mode
    pp_stb_i = 1;
    repeat (4) @(negedge clk);
    pp_stb_i = 0;
    repeat (4) begin
      chk(!pp_busy_o && !rx_valid && !pp_ack_o, "R11 ignored", pp_busy_o, 0);
      @(negedge clk);
    end

    // R10: control outputs one clock later
    cfg_init = 1; cfg_selin = 1; cfg_autofd = 1;
    chk(!init_o, "R10 not yet", init_o, 0);
    @(negedge clk);
    chk(init_o && selin_o && autofd_o, "R10 follow", init_o, 1);
    cfg_selin = 0;
    @(negedge clk);
    chk(init_o && !selin_o && autofd_o, "R10 single", selin_o, 0);

    // R2: reverse direction outputs, forward blocked
    cfg_dir = 1;
    @(negedge clk);
    chk(!dir_data_o && !dir_stb_o && dir_busy_o && dir_ack_o, "R2 dir", dir_data_o, 0);
    tx_valid = 1;
    @(negedge clk);
    chk(!tx_ready, "R5 reverse blocks tx", tx_ready, 0);
    tx_valid = 0;

    // R7 / R8: reverse byte with back-pressure
    begin
      int lat, aw;
      pp_data_i = 8'h5A;
      pp_stb_i = 1;
      lat = 0;
      while (!pp_busy_o && lat < 10) begin @(negedge clk); lat++; end
      chk(lat >= 2 && lat <= 3, "R7 busy latency", lat, 3);
      chk(rx_valid && rx_data == 8'h5A, "R7 rx data", rx_data, 8'h5A);
      repeat (2) @(negedge clk);
      pp_stb_i = 0;
      repeat (3) @(negedge clk);
      pp_data_i = 8'h00;
      chk(rx_valid && rx_data == 8'h5A && !pp_ack_o && pp_busy_o, "R7 stall", rx_data, 8'h5A);
      chk(!irq_o, "R9 disabled", irq_o, 0);
      rx_ready = 1; @(negedge clk); rx_ready = 0;
      aw = 0;
      while (pp_ack_o && aw < 10) begin
        chk(pp_busy_o, "R8 busy during ack", pp_busy_o, 1);
        aw++; @(negedge clk);
      end
      chk(aw == 3, "R8 ack width", aw, 3);
      @(negedge clk);
      chk(!pp_busy_o, "R8 busy release", pp_busy_o, 0);
      chk(!irq_o, "R9 gated", irq_o, 0);
      irq_en = 1;
      @(negedge clk);
      chk(irq_o, "R9 enable shows pending", irq_o, 1);
      irq_clr = 1; @(negedge clk); irq_clr = 0;
    end

    // R8: strobe still high after ack keeps busy
    begin
      int n;
      pp_data_i = 8'hC3;
      pp_stb_i = 1;
      repeat (4) @(negedge clk);
      chk(rx_data == 8'hC3, "R7 second byte", rx_data, 8'hC3);
      rx_ready = 1; @(negedge clk); rx_ready = 0;
      n = 0;
      while (pp_ack_o && n < 10) begin n++; @(negedge clk); end
      repeat (3) @(negedge clk);
      chk(pp_busy_o && !pp_ack_o, "R8 busy until strobe low", pp_busy_o, 1);
      pp_stb_i = 0;
      repeat (4) @(negedge clk);
      chk(!pp_busy_o, "R8 busy drops", pp_busy_o, 0);
      chk(irq_o, "R9 rev irq", irq_o, 1);
    end

    // R1: back to forward
    cfg_dir = 0;
    @(negedge clk);
    chk(dir_data_o && dir_stb_o && !dir_busy_o && !dir_ack_o, "R1 return", dir_busy_o, 0);

    summary();
  end
endmodule